// File: doc/BRIEF.md
# Configurable AND/OR Term Plane with Complement Feedback

This block is the combinational decision logic of a Mealy sequencer. It holds 64 configurable product terms. Each term is the AND of literals taken from 16 external inputs, 8 present-state bits fed back from a register bank outside this block, and 2 complement-array signals. Every term then drives any chosen set of J and K lines for 8 state registers and 8 output registers. The J/K lines are purely combinational. The flip-flops that consume them are outside this block.

Two complement arrays give a single term an ELSE meaning. Each array is the inverted OR of the terms that are enabled to feed it, so its output is high only when none of those terms matches. The array output comes back into every term as an extra literal. Evaluation therefore runs in two passes. The first pass evaluates every term on inputs and state only. The arrays are formed from that first pass. The second pass applies the complement literals.

Configuration goes in through a synchronous write port, one word per term. The word at the current address is visible at a combinational readback port. A write that would make a term feed a complement array whose output that same term reads is refused, and the refusal is reported.

Top module: `pla_seq_plane`

## Requirements
- R1: Each input and state literal of a term has a 2-bit code: 00 forces the term to 0, 01 needs the signal high, 10 needs it low, 11 ignores it. A term is the AND of all its literals.
- R2: After reset every word reads back as zero. All terms are therefore dead, and every J and K line stays low for any input and state.
- R3: Complement output k is high exactly when no term that has generate bit k set matches in the first pass. The first pass uses the input and state literals, and a term counts as dead there if either of its complement codes is 00.
- R4: The complement literal k of a term uses the same encoding as R1, applied to complement output k. A term is active only if it matches in the first pass and its complement literals are also satisfied.
- R5: Each J or K line is the OR of the active terms whose connection bit for that line is set. If no active term connects to a line, the line is low.
- R6: While clk_in_mode is high, the literal for input 5 is ignored in every term, whatever its code, including 00.
- R7: On a rising clk edge with cfg_we high, cfg_wdata is stored at cfg_addr. cfg_rdata always shows the word at cfg_addr. Word layout, from bit 0 upward:
  - input codes at bits [2i+1:2i];
  - state codes at bits 32+2s;
  - complement codes at bits 48+2k;
  - generate bits at bit 52+k;
  - state J at bit 54+r and state K at bit 62+r;
  - output J at bit 70+r and output K at bit 78+r.
- R8: A write whose generate bit k is set while its complement code k is 01 or 10 is not stored, and the old word is kept. cfg_reject is high in the cycle after each write and reflects only that write. A write whose generate bit and read complement code belong to different arrays is legal.
- R9: One term may drive several lines at once, including all 32. Several terms may drive the same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst | input | 1 | Synchronous reset, active high, clears every word |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 6 | Term index for write and readback |
| cfg_wdata | input | 86 | Term word to write |
| cfg_rdata | output | 86 | Word stored at cfg_addr |
| cfg_reject | output | 1 | High in the cycle after a refused write |
| din | input | 16 | External inputs |
| st_fb | input | 8 | Present-state feedback |
| clk_in_mode | input | 1 | Input 5 is used as a clock, so its literal is ignored |
| st_j | output | 8 | J lines of the state registers |
| st_k | output | 8 | K lines of the state registers |
| out_j | output | 8 | J lines of the output registers |
| out_k | output | 8 | K lines of the output registers |

## Verification
The hardest situation to reach from the ports is the one where a complement literal changes an outcome. That requires one term to feed an array and a second term, on another line, to read it. The array also has to flip only because of the state or input pattern, while every other term connected to the same lines stays quiet. The stimulus builds such pairs for both arrays, with one reader in true polarity and one in complement polarity. It then sweeps all 256 state patterns and all 256 low-input patterns, so that each array is seen both idle and busy. Directed vectors with hand-computed line patterns complete the checks. The refused-write path gets a legal word followed by a looping word at the same address, plus a cross-array word that must be accepted.

// File: rtl/pla_seq_pkg.sv
`timescale 1ns/1ps
package pla_seq_pkg;
  typedef enum logic [1:0] {
    LIT_OFF = 2'b00,
    LIT_HI  = 2'b01,
    LIT_LO  = 2'b10,
    LIT_ANY = 2'b11
  } lit_code_e;

  // One literal: does the signal satisfy the code?
  function automatic logic lit_pass(input logic [1:0] code, input logic sig);
    case (code)
      LIT_OFF: return 1'b0;
      LIT_HI:  return sig;
      LIT_LO:  return ~sig;
      default: return 1'b1;
    endcase
  endfunction

  // Does the code actually look at the signal?
  function automatic logic lit_reads(input logic [1:0] code);
    return (code == LIT_HI) || (code == LIT_LO);
  endfunction
endpackage

// File: rtl/pla_cfg_store.sv
`timescale 1ns/1ps
module pla_cfg_store #(
  parameter int N_TERM = 64,
  parameter int WW     = 86,
  parameter int N_CA   = 2,
  parameter int CC_LO  = 48,
  parameter int GN_LO  = 52,
  localparam int AW    = $clog2(N_TERM)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [WW-1:0] wdata,
  output logic [WW-1:0] rdata,
  output logic          reject,
  output logic [WW-1:0] words [N_TERM],
  output logic          wr_commit,
  output logic          wr_block
);
  import pla_seq_pkg::*;

  // A term that feeds array k must not also read array k
  function automatic logic self_loop(input logic [WW-1:0] w);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < N_CA; k++)
      hit = hit | (w[GN_LO+k] & lit_reads(w[CC_LO+2*k +: 2]));
    return hit;
  endfunction

  assign wr_block  = we & self_loop(wdata);
  assign wr_commit = we & ~wr_block;
  assign rdata     = words[addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      reject <= 1'b0;
      for (int t = 0; t < N_TERM; t++) words[t] <= '0;
    end else begin
      reject <= wr_block;
      if (wr_commit) words[addr] <= wdata;
    end
  end
endmodule

// File: rtl/pla_and_plane.sv
`timescale 1ns/1ps
module pla_and_plane #(
  parameter int N_TERM     = 64,
  parameter int N_IN       = 16,
  parameter int N_ST       = 8,
  parameter int N_CA       = 2,
  parameter int CLK_IN_IDX = 5
) (
  input  logic [N_IN-1:0]   din,
  input  logic [N_ST-1:0]   st_fb,
  input  logic              clk_in_mode,
  input  logic [2*N_IN-1:0] icode [N_TERM],
  input  logic [2*N_ST-1:0] scode [N_TERM],
  input  logic [2*N_CA-1:0] ccode [N_TERM],
  output logic [N_TERM-1:0] term_pre
);
  import pla_seq_pkg::*;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic hit;
    always_comb begin
      logic [1:0] c;
      hit = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        c = icode[t][2*i +: 2];
        if (clk_in_mode && (i == CLK_IN_IDX)) c = LIT_ANY;
        hit = hit & lit_pass(c, din[i]);
      end
      for (int s = 0; s < N_ST; s++)
        hit = hit & lit_pass(scode[t][2*s +: 2], st_fb[s]);
      // an inactive complement code kills the term in both passes
      for (int k = 0; k < N_CA; k++)
        hit = hit & (ccode[t][2*k +: 2] != LIT_OFF);
    end
    assign term_pre[t] = hit;
  end
endmodule

// File: rtl/pla_comp_feedback.sv
`timescale 1ns/1ps
module pla_comp_feedback #(
  parameter int N_TERM = 64,
  parameter int N_CA   = 2
) (
  input  logic [N_TERM-1:0] term_pre,
  input  logic [N_CA-1:0]   gen   [N_TERM],
  input  logic [2*N_CA-1:0] ccode [N_TERM],
  output logic [N_CA-1:0]   comp_out,
  output logic [N_TERM-1:0] term_hit
);
  import pla_seq_pkg::*;

  for (genvar k = 0; k < N_CA; k++) begin : g_arr
    logic busy;
    always_comb begin
      busy = 1'b0;
      for (int t = 0; t < N_TERM; t++) busy = busy | (term_pre[t] & gen[t][k]);
    end
    assign comp_out[k] = ~busy;
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_fin
    logic ok;
    always_comb begin
      ok = term_pre[t];
      for (int k = 0; k < N_CA; k++)
        ok = ok & lit_pass(ccode[t][2*k +: 2], comp_out[k]);
    end
    assign term_hit[t] = ok;
  end
endmodule

// File: rtl/pla_or_plane.sv
`timescale 1ns/1ps
module pla_or_plane #(
  parameter int N_TERM = 64,
  parameter int N_LINE = 32
) (
  input  logic [N_TERM-1:0] term_hit,
  input  logic [N_LINE-1:0] conn [N_TERM],
  output logic [N_LINE-1:0] drive
);
  for (genvar l = 0; l < N_LINE; l++) begin : g_line
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int t = 0; t < N_TERM; t++) acc = acc | (term_hit[t] & conn[t][l]);
    end
    assign drive[l] = acc;
  end
endmodule

// File: rtl/pla_seq_plane.sv
`timescale 1ns/1ps
module pla_seq_plane #(
  parameter int N_TERM     = 64,
  parameter int N_IN       = 16,
  parameter int N_ST       = 8,
  parameter int N_OUT      = 8,
  parameter int N_CA       = 2,
  parameter int CLK_IN_IDX = 5,
  localparam int AW     = $clog2(N_TERM),
  localparam int SC_LO  = 2*N_IN,
  localparam int CC_LO  = SC_LO + 2*N_ST,
  localparam int GN_LO  = CC_LO + 2*N_CA,
  localparam int JS_LO  = GN_LO + N_CA,
  localparam int N_LINE = 2*N_ST + 2*N_OUT,
  localparam int WW     = JS_LO + N_LINE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [WW-1:0]    cfg_wdata,
  output logic [WW-1:0]    cfg_rdata,
  output logic             cfg_reject,
  input  logic [N_IN-1:0]  din,
  input  logic [N_ST-1:0]  st_fb,
  input  logic             clk_in_mode,
  output logic [N_ST-1:0]  st_j,
  output logic [N_ST-1:0]  st_k,
  output logic [N_OUT-1:0] out_j,
  output logic [N_OUT-1:0] out_k
);
  logic [WW-1:0]     words [N_TERM];
  logic [2*N_IN-1:0] icode [N_TERM];
  logic [2*N_ST-1:0] scode [N_TERM];
  logic [2*N_CA-1:0] ccode [N_TERM];
  logic [N_CA-1:0]   gen   [N_TERM];
  logic [N_LINE-1:0] conn  [N_TERM];
  logic [N_TERM-1:0] term_pre, term_hit;
  logic [N_CA-1:0]   comp_out;
  logic [N_LINE-1:0] drive;
  logic              wr_commit, wr_block;

  pla_cfg_store #(.N_TERM(N_TERM), .WW(WW), .N_CA(N_CA), .CC_LO(CC_LO), .GN_LO(GN_LO)) u_store (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .reject(cfg_reject), .words(words),
    .wr_commit(wr_commit), .wr_block(wr_block)
  );

  for (genvar t = 0; t < N_TERM; t++) begin : g_split
    assign icode[t] = words[t][0     +: 2*N_IN];
    assign scode[t] = words[t][SC_LO +: 2*N_ST];
    assign ccode[t] = words[t][CC_LO +: 2*N_CA];
    assign gen[t]   = words[t][GN_LO +: N_CA];
    assign conn[t]  = words[t][JS_LO +: N_LINE];
  end

  pla_and_plane #(.N_TERM(N_TERM), .N_IN(N_IN), .N_ST(N_ST), .N_CA(N_CA),
                  .CLK_IN_IDX(CLK_IN_IDX)) u_and (
    .din(din), .st_fb(st_fb), .clk_in_mode(clk_in_mode),
    .icode(icode), .scode(scode), .ccode(ccode), .term_pre(term_pre)
  );

  pla_comp_feedback #(.N_TERM(N_TERM), .N_CA(N_CA)) u_comp (
    .term_pre(term_pre), .gen(gen), .ccode(ccode),
    .comp_out(comp_out), .term_hit(term_hit)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_LINE(N_LINE)) u_or (
    .term_hit(term_hit), .conn(conn), .drive(drive)
  );

  assign st_j  = drive[0 +: N_ST];
  assign st_k  = drive[N_ST +: N_ST];
  assign out_j = drive[2*N_ST +: N_OUT];
  assign out_k = drive[2*N_ST+N_OUT +: N_OUT];
endmodule

// File: rtl/pla_seq_plane_chk.sv
`timescale 1ns/1ps
module pla_seq_plane_chk #(
  parameter int N_TERM = 64,
  parameter int N_ST   = 8,
  parameter int N_OUT  = 8,
  parameter int N_CA   = 2,
  parameter int WW     = 86
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic              cfg_reject,
  input logic [WW-1:0]     cfg_rdata,
  input logic [N_TERM-1:0] term_pre,
  input logic [N_TERM-1:0] term_hit,
  input logic [N_CA-1:0]   comp_out,
  input logic [N_ST-1:0]   st_j,
  input logic [N_ST-1:0]   st_k,
  input logic [N_OUT-1:0]  out_j,
  input logic [N_OUT-1:0]  out_k
);
  AST_BLANK_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (term_pre == '0 && cfg_rdata == '0)); // R2
  AST_COMP_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (term_pre == '0) |-> (&comp_out)); // R3
  AST_HIT_NEEDS_PRE: assert property (@(posedge clk) disable iff (rst)
    ((term_hit & ~term_pre) == '0)); // R4
  AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (term_hit == '0) |-> ({st_j, st_k, out_j, out_k} == '0)); // R5
  AST_REJECT_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    cfg_reject |-> $past(cfg_we)); // R8
endmodule

bind pla_seq_plane pla_seq_plane_chk #(
  .N_TERM(N_TERM), .N_ST(N_ST), .N_OUT(N_OUT), .N_CA(N_CA), .WW(WW)
) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_reject(cfg_reject),
  .cfg_rdata(cfg_rdata), .term_pre(term_pre), .term_hit(term_hit),
  .comp_out(comp_out), .st_j(st_j), .st_k(st_k), .out_j(out_j), .out_k(out_k)
);

// File: tb/tb_pla_seq_plane.sv
`timescale 1ns/1ps
module tb_pla_seq_plane;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [85:0] cfg_wdata = '0;
  logic [85:0] cfg_rdata;
  logic        cfg_reject;
  logic [15:0] din = '0;
  logic [7:0]  st_fb = '0;
  logic        clk_in_mode = 1'b0;
  logic [7:0]  st_j, st_k, out_j, out_k;
  logic [31:0] got;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [85:0] cfgm [64];

  always #2 clk = ~clk;

  pla_seq_plane dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_reject(cfg_reject),
    .din(din), .st_fb(st_fb), .clk_in_mode(clk_in_mode),
    .st_j(st_j), .st_k(st_k), .out_j(out_j), .out_k(out_k)
  );

  assign got = {out_k, out_j, st_k, st_j};

  task automatic chk(input string tag, input logic [31:0] g, input logic [31:0] e);
    checks++;
    if (g !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, g, e);
    end
  endtask

  task automatic chk_word(input string tag, input logic [85:0] g, input logic [85:0] e);
    checks++;
    if (g !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, g, e);
    end
  endtask

  // all literals don't-care, no generate, no connection
  function automatic logic [85:0] base_word();
    logic [85:0] w;
    w = '0;
    w[51:0] = '1;
    return w;
  endfunction

  // expected lines {out_k,out_j,st_k,st_j}, restated from R1 and R3 to R6
  function automatic logic [31:0] model(input logic [15:0] d, input logic [7:0] s, input logic m);
    logic [63:0] pre, fin;
    logic [1:0]  cmp, code;
    logic [31:0] r;
    for (int t = 0; t < 64; t++) begin
      pre[t] = 1'b1;
      for (int i = 0; i < 16; i++) begin
        code = (m && i == 5) ? 2'b11 : cfgm[t][2*i +: 2];
        if (code == 2'b00 || (code == 2'b01 && !d[i]) || (code == 2'b10 && d[i])) pre[t] = 1'b0;
      end
      for (int b = 0; b < 8; b++) begin
        code = cfgm[t][32+2*b +: 2];
        if (code == 2'b00 || (code == 2'b01 && !s[b]) || (code == 2'b10 && s[b])) pre[t] = 1'b0;
      end
      if (cfgm[t][49:48] == 2'b00 || cfgm[t][51:50] == 2'b00) pre[t] = 1'b0;
    end
    cmp = 2'b11;
    for (int t = 0; t < 64; t++)
      for (int k = 0; k < 2; k++)
        if (pre[t] && cfgm[t][52+k]) cmp[k] = 1'b0;
    for (int t = 0; t < 64; t++) begin
      fin[t] = pre[t];
      for (int k = 0; k < 2; k++) begin
        code = cfgm[t][48+2*k +: 2];
        if ((code == 2'b01 && !cmp[k]) || (code == 2'b10 && cmp[k])) fin[t] = 1'b0;
      end
    end
    r = '0;
    for (int l = 0; l < 32; l++)
      for (int t = 0; t < 64; t++)
        if (fin[t] && cfgm[t][54+l]) r[l] = 1'b1;
    return r;
  endfunction

  task automatic apply(input logic [15:0] d, input logic [7:0] s, input logic m);
    @(negedge clk);
    din = d; st_fb = s; clk_in_mode = m;
    #1;
  endtask

  task automatic wr(input string tag, input int a, input logic [85:0] w, input logic exp_rej);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    chk(tag, {31'b0, cfg_reject}, {31'b0, exp_rej});
    if (!exp_rej) cfgm[a] = w;
  endtask

  task automatic read_chk(input string tag, input int a);
    @(negedge clk);
    cfg_addr = 6'(a);
    #1;
    chk_word(tag, cfg_rdata, cfgm[a]);
  endtask

  // sweep every state pattern, then every low-input byte
  task automatic sweep(input string tag, input logic m);
    for (int v = 0; v < 256; v++) begin
      logic [15:0] d;
      d = 16'($urandom);
      apply(d, 8'(v), m);
      chk(tag, got, model(d, 8'(v), m));
    end
    for (int v = 0; v < 256; v++) begin
      logic [15:0] d;
      logic [7:0]  s;
      d = 16'($urandom);
      d[7:0] = 8'(v);
      s = 8'($urandom);
      apply(d, s, m);
      chk(tag, got, model(d, s, m));
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [85:0] w;
    for (int t = 0; t < 64; t++) cfgm[t] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2: blank after reset
    #1;
    chk("R2 reject after reset", {31'b0, cfg_reject}, 32'h0);
    read_chk("R2 readback addr0", 0);
    read_chk("R2 readback addr63", 63);
    sweep("R2", 1'b0);

    // R7: write and read back, layout-sensitive word
    w = base_word(); w[1:0] = 2'b00; w[61:54] = 8'hA5; w[53] = 1'b1;
    wr("R7 write addr63", 63, w, 1'b0);
    read_chk("R7 readback addr63", 63);
    chk("R7 dead term drives nothing", got, 32'h0);

    // R1, R5, R9 configuration
    w = base_word(); w[1:0] = 2'b01; w[3:2] = 2'b10; w[37:36] = 2'b01; w[54] = 1'b1;
    wr("R7 write t0", 0, w, 1'b0);
    w = base_word(); w[7:6] = 2'b01; w[47:46] = 2'b10; w[54] = 1'b1; w[78+5] = 1'b1;
    wr("R7 write t1", 1, w, 1'b0);
    w = base_word(); w[5:4] = 2'b00; w[70+7] = 1'b1;
    wr("R7 write t6", 6, w, 1'b0);
    read_chk("R7 readback t0", 0);
    apply(16'h0001, 8'h04, 1'b0); chk("R1 true/complement/state match", got, 32'h0000_0001);
    apply(16'h0003, 8'h04, 1'b0); chk("R1 complement literal blocks", got, 32'h0);
    apply(16'h0001, 8'h00, 1'b0); chk("R1 state literal blocks", got, 32'h0);
    apply(16'hFFF4, 8'h00, 1'b0); chk("R1 inactive code kills term", got, 32'h0);
    apply(16'h0008, 8'h00, 1'b0); chk("R9 one term on J and K lines", got, 32'h2000_0001);
    apply(16'h0009, 8'h04, 1'b0); chk("R5 two terms OR on one line", got, 32'h2000_0001);
    apply(16'h0008, 8'h80, 1'b0); chk("R5 no active term leaves lines low", got, 32'h0);
    sweep("R1", 1'b0);

    // R3, R4 configuration
    w = base_word(); w[35:34] = 2'b01; w[52] = 1'b1;
    wr("R7 write t10", 10, w, 1'b0);
    w = base_word(); w[5:4] = 2'b01; w[53] = 1'b1;
    wr("R7 write t11", 11, w, 1'b0);
    w = base_word(); w[49:48] = 2'b01; w[70] = 1'b1;
    wr("R7 write t12", 12, w, 1'b0);
    w = base_word(); w[49:48] = 2'b10; w[78] = 1'b1;
    wr("R7 write t13", 13, w, 1'b0);
    w = base_word(); w[49:48] = 2'b01; w[51:50] = 2'b01; w[71] = 1'b1;
    wr("R7 write t14", 14, w, 1'b0);
    w = base_word(); w[51:50] = 2'b00; w[79] = 1'b1;
    wr("R7 write t15", 15, w, 1'b0);
    apply(16'h0000, 8'h00, 1'b0); chk("R3 both arrays idle high", got, 32'h0003_0000);
    apply(16'h0000, 8'h02, 1'b0); chk("R4 array 0 busy selects else term", got, 32'h0100_0000);
    apply(16'h0004, 8'h00, 1'b0); chk("R3 array 1 busy, array 0 idle", got, 32'h0001_0000);
    apply(16'h0004, 8'h02, 1'b0); chk("R4 inactive C code never fires", got, 32'h0100_0000);
    sweep("R3", 1'b0);

    // R6 configuration
    w = base_word(); w[11:10] = 2'b00; w[62+7] = 1'b1;
    wr("R7 write t20", 20, w, 1'b0);
    w = base_word(); w[11:10] = 2'b01; w[1:0] = 2'b10; w[54+6] = 1'b1;
    wr("R7 write t21", 21, w, 1'b0);
    apply(16'h0000, 8'h00, 1'b1); chk("R6 input 5 ignored in clock mode", got, 32'h0003_8040);
    apply(16'h0000, 8'h00, 1'b0); chk("R6 input 5 honoured otherwise", got, 32'h0003_0000);
    apply(16'h0020, 8'h00, 1'b0); chk("R6 input 5 high, normal mode", got, 32'h0003_0040);
    sweep("R6 mode0", 1'b0);
    sweep("R6 mode1", 1'b1);

    // R9: one term on all 32 lines
    w = base_word(); w[45:44] = 2'b01; w[43:42] = 2'b01; w[85:54] = '1;
    wr("R7 write t30", 30, w, 1'b0);
    apply(16'h0000, 8'h60, 1'b0); chk("R9 term drives every line", got, 32'hFFFF_FFFF);
    apply(16'h0000, 8'h20, 1'b0); chk("R9 term off again", got, 32'h0003_0000);
    sweep("R9", 1'b0);

    // R8: loop writes are refused
    w = base_word(); w[52] = 1'b1; w[31:30] = 2'b01;
    wr("R8 legal write", 40, w, 1'b0);
    w = base_word(); w[52] = 1'b1; w[49:48] = 2'b10;
    wr("R8 loop on array 0 refused", 40, w, 1'b1);
    read_chk("R8 word kept after refusal", 40);
    @(negedge clk); #1;
    chk("R8 reject drops without write", {31'b0, cfg_reject}, 32'h0);
    w = base_word(); w[53] = 1'b1; w[51:50] = 2'b01;
    wr("R8 loop on array 1 refused", 41, w, 1'b1);
    read_chk("R8 addr41 still blank", 41);
    w = base_word(); w[52] = 1'b1; w[51:50] = 2'b01;
    wr("R8 cross-array word accepted", 42, w, 1'b0);
    read_chk("R8 cross-array readback", 42);
    sweep("R8 after writes", 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule